// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the programmable start address and transfer length of four DMA channels, together with the live position of each channel. A host reaches the registers through a byte-wide port that has eight register offsets. Every 16-bit register is read or written as two byte accesses. One byte-pointer flip-flop, shared by all channels, decides whether an access targets the low byte or the high byte. A transfer engine outside this block pulses one advance strobe per channel for each unit it moves, and the host can read back the current address and the remaining count at any time.

Completing the high byte of any write restarts the channel. Its current address is reloaded from the programmed start address and its progress returns to zero. A parameter selects the wide-controller variant. In that variant the register offsets sit on even port addresses and the address and count arithmetic is done one bit position up, so each unit of progress is half a unit of the host-visible value.

Top module: `dma_addr_count_bank`

## Requirements
- R1: The register offset is `host_port >> W`, where W is the WIDE parameter (0 or 1). Offset bits [2:1] select channel 0 to 3, and offset bit 0 selects the start address (0) or the length (1).
- R2: A single byte pointer is shared by every channel. Any access (`host_sel` high with `host_rd` or `host_wr` high) toggles it at the clock edge, reads included. Pointer value 0 means the low byte and 1 means the high byte. When `host_rd` and `host_wr` are both high, the access is a write and toggles the pointer once.
- R3: A write with the pointer at 1 stores `host_wdata` into bits [15:8] of the selected register. It then reloads that channel's current address with the start address shifted left by W (using the new value) and sets the channel's progress to zero.
- R4: A write with the pointer at 0 stores `host_wdata` into bits [7:0] of the selected register only. The channel's current address and progress are unchanged.
- R5: An address read returns the current address plus progress when `dir_down[ch]` is 0, or minus progress when it is 1. The result is taken modulo 2^(16+W).
- R6: Each cycle with `advance[ch]` high adds one to that channel's progress. A high-byte write to the same channel in the same cycle takes precedence and leaves the progress at zero.
- R7: A length read returns (programmed length shifted left by W) minus progress, modulo 2^(16+W).
- R8: The byte returned is bits [W+7:W] of the value when the pointer is 0, and bits [W+15:W+8] when it is 1.
- R9: With W=1, port bit 0 is ignored. The start address is loaded into the current address shifted left by 1, so one advance moves the host-visible address by one half.
- R10: `ptr_clear` forces the pointer to 0 at the next edge, overriding a toggle from an access in the same cycle. Reset clears every register, every progress count and the pointer.
- R11: `host_rdata` is 0 in every cycle without a pure read (`host_sel` and `host_rd` high with `host_wr` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host selects the channel register port |
| host_rd | input | 1 | Read access |
| host_wr | input | 1 | Write access |
| host_port | input | 3+WIDE | Register port address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid during a read cycle |
| ptr_clear | input | 1 | Clear the byte pointer (from a clear command or a master reset) |
| advance | input | 4 | Per-channel progress strobe from the transfer engine |
| dir_down | input | 4 | Per-channel decrement mode for address reads |

## Verification
Directed sequences use the two port addresses that decode to the same register in both variants. This separates the plain variant from the scaled one: after three advances an address of 0x1234 reads back as 0x1237 in one variant and 0x1235 in the other. Further sequences interleave reads and writes without a pointer clear. They show that reads also move the shared pointer, because a following write then lands on the high byte and restarts the channel. Other sequences clear the pointer in the same cycle as an access, flip the direction after advancing, and write only a low byte, which shows that the live position is left alone. A long random phase then mixes simultaneous read and write requests, advances colliding with restarts, and direction changes. A behavioural model of both variants checks every cycle.

// File: rtl/dab_pkg.sv
// Shared constants and types for the DMA address/count register bank.
package dab_pkg;
    localparam int BYTE_W = 8;   // host data path width
    localparam int REG_W  = 16;  // programmed register width
    localparam int NUM_CH = 4;   // channels decoded by offset bits [2:1]
    localparam int CH_W   = 2;   // channel index width
    localparam int IDX_W  = 3;   // register offset width

    // Register kind picked by offset bit 0
    typedef enum logic {
        REG_ADDR  = 1'b0,
        REG_COUNT = 1'b1
    } reg_kind_e;
endpackage

// File: rtl/dab_byte_ptr.sv
// Shared low/high byte pointer.
// Toggles on every register access; a clear request wins over a toggle.
// Assumes access and clear_req are synchronous to clk.
module dab_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clear_req,
    output logic ptr_hi
);
    // Pointer state: clear, else toggle on access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_hi <= 1'b0;
        end else if (clear_req) begin
            ptr_hi <= 1'b0;
        end else if (access) begin
            ptr_hi <= ~ptr_hi;
        end
    end
endmodule

// File: rtl/dab_port_decode.sv
// Host port decoder: strips the variant scaling from the port address and
// splits the offset into channel index and register kind.
// Assumes host_rd/host_wr are single-cycle qualified by host_sel.
module dab_port_decode
    import dab_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic                 host_sel,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [IDX_W+SHIFT-1:0] host_port,
    output logic                 access,
    output logic                 is_write,
    output logic                 rd_active,
    output logic [CH_W-1:0]      ch_idx,
    output reg_kind_e            kind
);
    logic [IDX_W-1:0] offset;

    // Offset extraction above the scaling bits
    assign offset = host_port[SHIFT +: IDX_W];

    generate
        if (SHIFT > 0) begin : g_scaled
            logic dec_unused_lsb;
            // Low port bits carry no register selection in the scaled variant
            assign dec_unused_lsb = ^host_port[SHIFT-1:0];
        end
    endgenerate

    // Access qualification and field split
    always_comb begin
        access    = host_sel && (host_rd || host_wr);
        is_write  = host_sel && host_wr;
        rd_active = host_sel && host_rd && !host_wr;
        ch_idx    = offset[IDX_W-1:1];
        kind      = reg_kind_e'(offset[0]);
    end
endmodule

// File: rtl/dab_channel.sv
// One channel: programmed start address and length, live current address
// and progress count, and the two host-visible views derived from them.
// Assumes at most one write per cycle; wr_high comes from the shared pointer.
module dab_channel
    import dab_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CUR_W = REG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic              wr_high,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              advance,
    input  logic              dir_down,
    output logic [CUR_W-1:0]  addr_view,
    output logic [CUR_W-1:0]  count_view,
    output logic [REG_W-1:0]  start_addr,
    output logic [CUR_W-1:0]  cur_addr,
    output logic [CUR_W-1:0]  progress
);
    logic [REG_W-1:0] length_q;
    logic [REG_W-1:0] start_nx;
    logic [REG_W-1:0] length_nx;
    logic             restart;

    // Byte merge of the host write into the selected register
    always_comb begin
        start_nx  = start_addr;
        length_nx = length_q;
        if (wr_en) begin
            if (wr_kind == REG_ADDR) begin
                if (wr_high) start_nx[REG_W-1:BYTE_W] = wdata;
                else         start_nx[BYTE_W-1:0]     = wdata;
            end else begin
                if (wr_high) length_nx[REG_W-1:BYTE_W] = wdata;
                else         length_nx[BYTE_W-1:0]     = wdata;
            end
        end
        restart = wr_en && wr_high;
    end

    // Programmed register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            length_q   <= '0;
        end else begin
            start_addr <= start_nx;
            length_q   <= length_nx;
        end
    end

    // Live position: restart on high-byte write, else count advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            progress <= '0;
        end else if (restart) begin
            cur_addr <= CUR_W'(start_nx) << SHIFT;
            progress <= '0;
        end else if (advance) begin
            progress <= progress + 1'b1;
        end
    end

    // Host views: moving address and remaining length
    always_comb begin
        addr_view  = dir_down ? (cur_addr - progress) : (cur_addr + progress);
        count_view = (CUR_W'(length_q) << SHIFT) - progress;
    end
endmodule

// File: rtl/dab_read_select.sv
// Read path: picks the channel view, removes the variant scaling and
// returns the byte named by the shared pointer; zero outside reads.
module dab_read_select
    import dab_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CUR_W = REG_W + SHIFT
) (
    input  logic [NUM_CH-1:0][CUR_W-1:0] addr_views,
    input  logic [NUM_CH-1:0][CUR_W-1:0] count_views,
    input  logic [CH_W-1:0]              ch_idx,
    input  reg_kind_e                    kind,
    input  logic                         ptr_hi,
    input  logic                         rd_active,
    output logic [BYTE_W-1:0]            rdata
);
    logic [CUR_W-1:0] picked;
    logic [CUR_W-1:0] unscaled;

    // View selection, descaling and byte pick
    always_comb begin
        picked   = (kind == REG_COUNT) ? count_views[ch_idx] : addr_views[ch_idx];
        unscaled = picked >> SHIFT;
        if (!rd_active)  rdata = '0;
        else if (ptr_hi) rdata = unscaled[REG_W-1:BYTE_W];
        else             rdata = unscaled[BYTE_W-1:0];
    end
endmodule

// File: rtl/dma_addr_count_bank.sv
// DMA address/count register bank, top level.
// Four channels behind a byte-wide host port with one shared byte pointer.
// WIDE=1 selects the scaled variant (even port offsets, values one bit up).
// Assumes the transfer engine raises advance[i] once per moved unit.
module dma_addr_count_bank
    import dab_pkg::*;
#(
    parameter int WIDE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [IDX_W+WIDE-1:0] host_port,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic                ptr_clear,
    input  logic [NUM_CH-1:0]   advance,
    input  logic [NUM_CH-1:0]   dir_down
);
    localparam int SHIFT = WIDE;
    localparam int CUR_W = REG_W + SHIFT;

    logic                         acc;
    logic                         is_write;
    logic                         rd_active;
    logic [CH_W-1:0]              ch_idx;
    reg_kind_e                    kind;
    logic                         ptr_hi;
    logic [NUM_CH-1:0]            ch_wr;
    logic [NUM_CH-1:0][CUR_W-1:0] addr_views;
    logic [NUM_CH-1:0][CUR_W-1:0] count_views;
    logic [NUM_CH-1:0][REG_W-1:0] start_addrs;
    logic [NUM_CH-1:0][CUR_W-1:0] cur_addrs;
    logic [NUM_CH-1:0][CUR_W-1:0] progs;

    dab_port_decode #(.SHIFT(SHIFT)) u_dec (
        .host_sel  (host_sel),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_port (host_port),
        .access    (acc),
        .is_write  (is_write),
        .rd_active (rd_active),
        .ch_idx    (ch_idx),
        .kind      (kind)
    );

    dab_byte_ptr u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (acc),
        .clear_req (ptr_clear),
        .ptr_hi    (ptr_hi)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // Per-channel write enable from the decoded index
            assign ch_wr[i] = is_write && (ch_idx == CH_W'(i));

            dab_channel #(.SHIFT(SHIFT)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (ch_wr[i]),
                .wr_kind    (kind),
                .wr_high    (ptr_hi),
                .wdata      (host_wdata),
                .advance    (advance[i]),
                .dir_down   (dir_down[i]),
                .addr_view  (addr_views[i]),
                .count_view (count_views[i]),
                .start_addr (start_addrs[i]),
                .cur_addr   (cur_addrs[i]),
                .progress   (progs[i])
            );
        end
    endgenerate

    dab_read_select #(.SHIFT(SHIFT)) u_rd (
        .addr_views  (addr_views),
        .count_views (count_views),
        .ch_idx      (ch_idx),
        .kind        (kind),
        .ptr_hi      (ptr_hi),
        .rd_active   (rd_active),
        .rdata       (host_rdata)
    );
endmodule

// File: rtl/dab_checker.sv
// Property checker for the register bank, bound into every instance.
module dab_checker
    import dab_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CUR_W = REG_W + SHIFT
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         acc,
    input logic                         ptr_clear,
    input logic                         ptr_hi,
    input logic                         rd_active,
    input logic [BYTE_W-1:0]            host_rdata,
    input logic [NUM_CH-1:0]            ch_wr,
    input logic [NUM_CH-1:0]            advance,
    input logic [NUM_CH-1:0][REG_W-1:0] start_addrs,
    input logic [NUM_CH-1:0][CUR_W-1:0] cur_addrs,
    input logic [NUM_CH-1:0][CUR_W-1:0] progs
);
    // R2: every access flips the shared pointer
    a_r2_ptr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ptr_clear) |=> (ptr_hi != $past(ptr_hi)));

    // R10: clear request forces the low byte
    a_r10_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> !ptr_hi);

    // R11: no read, no data
    a_r11_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> (host_rdata == '0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R3: high-byte write restarts the channel from its start address
            a_r3_high_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_wr[i] && ptr_hi) |=>
                    (progs[i] == '0) && (cur_addrs[i] == (CUR_W'(start_addrs[i]) << SHIFT)));

            // R4: low-byte write leaves the live position alone
            a_r4_low_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_wr[i] && !ptr_hi && !advance[i]) |=>
                    ($stable(progs[i]) && $stable(cur_addrs[i])));

            // R6: one advance adds exactly one unit
            a_r6_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
                (advance[i] && !(ch_wr[i] && ptr_hi)) |=>
                    (progs[i] == CUR_W'($past(progs[i]) + 1'b1)));
        end
    endgenerate
endmodule

bind dma_addr_count_bank dab_checker #(.SHIFT(SHIFT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .ptr_clear   (ptr_clear),
    .ptr_hi      (ptr_hi),
    .rd_active   (rd_active),
    .host_rdata  (host_rdata),
    .ch_wr       (ch_wr),
    .advance     (advance),
    .start_addrs (start_addrs),
    .cur_addrs   (cur_addrs),
    .progs       (progs)
);

// File: tb/tb_dma_addr_count_bank.sv
// Bench: both variants driven by one stimulus stream, checked every cycle
// against a behavioural model, plus directed hand-computed checks.
module tb_dma_addr_count_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, clr = 1'b0;
    logic [3:0] port = '0;
    logic [7:0] wdata = '0;
    logic [3:0] adv = '0, dn = '0;
    logic [7:0] rdata_n, rdata_w;

    int  checks = 0;
    int  errors = 0;
    bit  run_chk = 1'b0;
    bit  done = 1'b0;

    // Model state, index [variant][channel]
    int  m_start [2][4];
    int  m_len   [2][4];
    int  m_cur   [2][4];
    int  m_prog  [2][4];
    bit  m_ptr;

    always #2 clk = ~clk;

    dma_addr_count_bank #(.WIDE(0)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_rd(rd), .host_wr(wr),
        .host_port(port[2:0]), .host_wdata(wdata), .host_rdata(rdata_n),
        .ptr_clear(clr), .advance(adv), .dir_down(dn)
    );

    dma_addr_count_bank #(.WIDE(1)) dut_wide (
        .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_rd(rd), .host_wr(wr),
        .host_port(port), .host_wdata(wdata), .host_rdata(rdata_w),
        .ptr_clear(clr), .advance(adv), .dir_down(dn)
    );

    function automatic int vmask(int s);
        return (1 << (16 + s)) - 1;
    endfunction

    function automatic int offs(int s);
        return (s == 0) ? int'(port[2:0]) : int'(port[3:1]);
    endfunction

    // Expected read byte from the model for variant s
    function automatic int exp_rdata(int s);
        int idx, ch, v;
        if (!(sel && rd && !wr)) return 0;
        idx = offs(s);
        ch  = idx >> 1;
        if (idx & 1) v = ((m_len[s][ch] << s) - m_prog[s][ch]) & vmask(s);
        else if (dn[ch]) v = (m_cur[s][ch] - m_prog[s][ch]) & vmask(s);
        else v = (m_cur[s][ch] + m_prog[s][ch]) & vmask(s);
        return (v >> (s + (m_ptr ? 8 : 0))) & 8'hFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison: R11 idle, R7 length, R5 address (R8 byte pick)
    always @(negedge clk) begin
        if (run_chk) begin
            string tg;
            if (!(sel && rd && !wr)) tg = "R11";
            else if (offs(0) & 1) tg = "R7";
            else tg = "R5";
            check({tg, " narrow"}, int'(rdata_n), exp_rdata(0));
            if (!(sel && rd && !wr)) tg = "R11";
            else if (offs(1) & 1) tg = "R7";
            else tg = "R9";
            check({tg, " wide"}, int'(rdata_w), exp_rdata(1));
        end
    end

    // Model update at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int c = 0; c < 4; c++) begin
                    m_start[s][c] = 0; m_len[s][c] = 0;
                    m_cur[s][c] = 0;   m_prog[s][c] = 0;
                end
            m_ptr = 1'b0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                for (int c = 0; c < 4; c++)
                    if (adv[c]) m_prog[s][c] = (m_prog[s][c] + 1) & vmask(s);
                if (sel && wr) begin
                    int idx, c;
                    idx = offs(s);
                    c = idx >> 1;
                    if (m_ptr) begin
                        if (idx & 1) m_len[s][c] = (m_len[s][c] & 8'hFF) | (int'(wdata) << 8);
                        else m_start[s][c] = (m_start[s][c] & 8'hFF) | (int'(wdata) << 8);
                        m_cur[s][c]  = (m_start[s][c] << s) & vmask(s);
                        m_prog[s][c] = 0;
                    end else begin
                        if (idx & 1) m_len[s][c] = (m_len[s][c] & 16'hFF00) | int'(wdata);
                        else m_start[s][c] = (m_start[s][c] & 16'hFF00) | int'(wdata);
                    end
                end
            end
            if (clr) m_ptr = 1'b0;
            else if (sel && (rd || wr)) m_ptr = ~m_ptr;
        end
    end

    // Tasks start just after a rising edge and return just after the next one
    task automatic idle_to_next();
        sel = 0; rd = 0; wr = 0; clr = 0; adv = '0;
    endtask

    task automatic host_write(int p, int d);
        sel = 1; wr = 1; rd = 0; port = 4'(p); wdata = 8'(d);
        @(posedge clk); #1; idle_to_next();
    endtask

    task automatic host_read(int p, bit with_clr, output int vn, output int vw);
        sel = 1; rd = 1; wr = 0; port = 4'(p); clr = with_clr;
        @(negedge clk); vn = int'(rdata_n); vw = int'(rdata_w);
        @(posedge clk); #1; idle_to_next();
    endtask

    task automatic clear_ptr();
        clr = 1; @(posedge clk); #1; idle_to_next();
    endtask

    task automatic pulse_adv(int c, int n);
        for (int k = 0; k < n; k++) begin
            adv = 4'(1 << c); @(posedge clk); #1; idle_to_next();
        end
    endtask

    initial begin
        int vn, vw;
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int vn, vw;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1; run_chk = 1;

        // R10: after reset every register and the pointer read as zero
        host_read(0, 0, vn, vw);
        check("R10 reset addr lo", vn, 0);
        host_read(15, 0, vn, vw);
        check("R10 reset count hi", vw, 0);

        // R1 R3 R8: port 0 is channel 0 address in both variants
        clear_ptr();
        host_write(0, 8'h34);
        host_write(0, 8'h12);
        host_read(0, 0, vn, vw);
        check("R8 lo narrow", vn, 8'h34);
        check("R9 lo wide", vw, 8'h34);
        host_read(0, 0, vn, vw);
        check("R1 hi narrow", vn, 8'h12);
        check("R1 hi wide", vw, 8'h12);

        // R6 R9: three advances; wide value moves by half
        pulse_adv(0, 3);
        host_read(0, 0, vn, vw);
        check("R6 narrow", vn, 8'h37);
        check("R9 wide", vw, 8'h35);

        // R5: decrement direction
        dn[0] = 1'b1;
        clear_ptr();
        host_read(0, 0, vn, vw);
        check("R5 down narrow", vn, 8'h31);
        check("R5 down wide", vw, 8'h32);

        // R4: low byte write keeps live position
        clear_ptr();
        host_write(0, 8'hAA);
        clear_ptr();
        host_read(0, 0, vn, vw);
        check("R4 narrow", vn, 8'h31);
        check("R4 wide", vw, 8'h32);

        // R3: high byte write restarts from the new start address
        clear_ptr();
        host_write(0, 8'hAA);
        host_write(0, 8'h12);
        clear_ptr();
        host_read(0, 0, vn, vw);
        check("R3 restart narrow", vn, 8'hAA);
        check("R3 restart wide", vw, 8'hAA);

        // R2: a read moves the pointer, so the next write is a high byte
        pulse_adv(0, 1);
        clear_ptr();
        host_read(0, 0, vn, vw);
        host_write(0, 8'h56);
        clear_ptr();
        host_read(0, 0, vn, vw);
        check("R2 restart lo", vn, 8'hAA);
        host_read(0, 0, vn, vw);
        check("R2 new hi", vn, 8'h56);

        // R10: clear in the same cycle as an access wins
        clear_ptr();
        host_read(0, 1, vn, vw);
        host_read(0, 0, vn, vw);
        check("R10 clear wins", vn, 8'hAA);

        // R7: length on port 15 (channel 3 length in both variants)
        clear_ptr();
        host_write(15, 8'h05);
        host_write(15, 8'h00);
        pulse_adv(3, 2);
        host_read(15, 0, vn, vw);
        check("R7 narrow", vn, 8'h03);
        check("R7 wide", vw, 8'h04);

        // R11: read strobe without select returns zero
        rd = 1; @(negedge clk);
        check("R11 unselected", int'(rdata_n), 0);
        @(posedge clk); #1; idle_to_next();

        // Random phase with every input mixed
        for (int n = 0; n < 4000; n++) begin
            sel   = ($urandom_range(0, 3) != 0);
            rd    = $urandom_range(0, 1);
            wr    = ($urandom_range(0, 3) == 0);
            port  = 4'($urandom_range(0, 15));
            wdata = 8'($urandom_range(0, 255));
            adv   = 4'($urandom_range(0, 15));
            dn    = 4'($urandom_range(0, 15));
            clr   = ($urandom_range(0, 15) == 0);
            @(posedge clk); #1;
        end
        idle_to_next();
        @(posedge clk); #1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule